// File: doc/BRIEF.md
# Channel Control Register with LED Blinker

This block holds the one-byte control register found in the shared register area of a two-channel CAN interface. It sits on an 8-bit host register bus with an address, a write strobe, write data and combinational read data. The register's contents drive three sets of outputs. Two bits form a clock-select code for the controller oscillator. One bit per channel holds that channel's CAN controller in reset. A two-bit field per channel sets the mode of that channel's status LED.

The block makes the LED waveforms itself from one free-running prescaler. Each LED can be steady on, blink fast, blink slow or stay dark. Changing a mode does not restart the prescaler, so the blink phase of each channel stays tied to a single shared timebase. Two read-only bytes in the same area return the firmware version, major and minor.

Top module: `chanctl_led_reg`

## Requirements
- R1: While rst_n is low, the control register reads 0xFC and the blink counter is zero. As a result, clk_sel is 00, ctl_rst is 11 and led_n is 11.
- R2: A write with bus_addr = 0x40 loads bus_wdata into the control register at that clock edge. From the next cycle on, a read at 0x40 returns the last value written.
- R3: clk_sel equals control bits [1:0]. The codes are 00 for 16 MHz, 01 for 10 MHz, 10 for 21 MHz and 11 for 8 MHz.
- R4: ctl_rst[0] equals control bit 2 and ctl_rst[1] equals control bit 3. Each is active high and holds its channel's controller in reset.
- R5: The LED mode of channel 0 is in bits [5:4] and that of channel 1 is in bits [7:6]. Mode 00 drives led_n of that channel low (lit) and mode 11 drives it high (dark).
- R6: In mode 01 (fast), a channel's LED is lit exactly when bit BLINK_N of the cycle count since reset is 1. It therefore toggles every 2^BLINK_N clocks and starts dark.
- R7: In mode 10 (slow), a channel's LED is lit exactly when bit BLINK_N+2 of the cycle count since reset is 1. It therefore toggles every 2^(BLINK_N+2) clocks.
- R8: A new LED mode shows on led_n in the cycle after the write. The blink counter keeps counting and is not restarted.
- R9: A read at 0x50 returns FW_MAJOR and a read at 0x52 returns FW_MINOR. Writes to these addresses leave the control register unchanged.
- R10: A read at any other address returns 0x00, and a write to any other address leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| clk_sel | output | 2 | Oscillator clock-select code |
| ctl_rst | output | 2 | Per-channel controller reset, active high |
| led_n | output | 2 | Per-channel LED drive, active low |

## Verification
The bench first holds the register at its reset value for a long stretch, which shows that both LEDs stay dark and that the prescaler runs even while nothing blinks. It then writes combinations that put one channel in fast blink and the other in slow blink, swaps them, and later sets them steady or dark. These patterns show whether the two fields are decoded into the right channels and whether each mode follows the right prescaler bit. Some writes change a mode partway through a blink period, which shows whether the counter is restarted. Writes to the firmware bytes and to unmapped addresses, with the register read back afterwards, separate correct address decoding from stray loads.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;

   localparam int CHANNELS = 2;

   typedef enum logic [1:0] {
      LED_STEADY = 2'b00,
      LED_FAST   = 2'b01,
      LED_SLOW   = 2'b10,
      LED_DARK   = 2'b11
   } led_mode_e;

   typedef struct packed {
      led_mode_e  led1;     // [7:6]
      led_mode_e  led0;     // [5:4]
      logic [1:0] hold;     // [3:2] per-channel reset, bit 2 = channel 0
      logic [1:0] clk_code; // [1:0]
   } ctrl_t;

   localparam logic [7:0] CTRL_RESET = 8'hFC;

endpackage

// File: rtl/ccr_regs.sv
module ccr_regs
   import chanctl_pkg::*;
#(
   parameter int         ADDR_W     = 7,
   parameter int         CTRL_ADDR  = 'h40,
   parameter int         FWMAJ_ADDR = 'h50,
   parameter int         FWMIN_ADDR = 'h52,
   parameter logic [7:0] FW_MAJOR   = 8'h02,
   parameter logic [7:0] FW_MINOR   = 8'h05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output ctrl_t             ctrl_q
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_FWMAJ = ADDR_W'(FWMAJ_ADDR);
   localparam logic [ADDR_W-1:0] A_FWMIN = ADDR_W'(FWMIN_ADDR);

   initial begin
      assert (CTRL_ADDR < (1 << ADDR_W) && FWMAJ_ADDR < (1 << ADDR_W)
              && FWMIN_ADDR < (1 << ADDR_W))
         else $error("ccr_regs: an address does not fit in ADDR_W bits");
      assert (CTRL_ADDR != FWMAJ_ADDR && CTRL_ADDR != FWMIN_ADDR
              && FWMAJ_ADDR != FWMIN_ADDR)
         else $error("ccr_regs: register addresses overlap");
   end

   logic ctrl_sel;
   assign ctrl_sel = (bus_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= ctrl_t'(CTRL_RESET);
      end else if (bus_wr && ctrl_sel) begin
         ctrl_q <= ctrl_t'(bus_wdata);
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  bus_rdata = ctrl_q;
         A_FWMAJ: bus_rdata = FW_MAJOR;
         A_FWMIN: bus_rdata = FW_MINOR;
         default: bus_rdata = 8'h00;
      endcase
   end

   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL) |=> (ctrl_q == $past(bus_wdata))); // R2

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_CTRL) |=> $stable(ctrl_q)); // R10

endmodule

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
   parameter int BLINK_N = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic fast_ph,
   output logic slow_ph
);

   localparam int CNT_W = BLINK_N + 3;

   initial begin
      assert (BLINK_N >= 1 && BLINK_N <= 28)
         else $error("blink_prescaler: BLINK_N out of range");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign fast_ph = cnt_q[BLINK_N];
   assign slow_ph = cnt_q[BLINK_N+2];

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R8

   AST_SLOW_AFTER_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slow_ph) |-> $fell(fast_ph)); // R7

endmodule

// File: rtl/led_lamp.sv
module led_lamp
   import chanctl_pkg::*;
(
   input  led_mode_e mode,
   input  logic      fast_ph,
   input  logic      slow_ph,
   output logic      led_n
);

   logic lit;

   always_comb begin
      unique case (mode)
         LED_STEADY: lit = 1'b1;
         LED_FAST:   lit = fast_ph;
         LED_SLOW:   lit = slow_ph;
         default:    lit = 1'b0;
      endcase
   end

   assign led_n = ~lit;

endmodule

// File: rtl/chanctl_led_reg.sv
module chanctl_led_reg
   import chanctl_pkg::*;
#(
   parameter int         ADDR_W     = 7,
   parameter int         CTRL_ADDR  = 'h40,
   parameter int         FWMAJ_ADDR = 'h50,
   parameter int         FWMIN_ADDR = 'h52,
   parameter logic [7:0] FW_MAJOR   = 8'h02,
   parameter logic [7:0] FW_MINOR   = 8'h05,
   parameter int         BLINK_N    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic [1:0]        clk_sel,
   output logic [1:0]        ctl_rst,
   output logic [1:0]        led_n
);

   ctrl_t     ctrl;
   logic      fast_ph;
   logic      slow_ph;
   led_mode_e chan_mode [CHANNELS];

   ccr_regs #(
      .ADDR_W     (ADDR_W),
      .CTRL_ADDR  (CTRL_ADDR),
      .FWMAJ_ADDR (FWMAJ_ADDR),
      .FWMIN_ADDR (FWMIN_ADDR),
      .FW_MAJOR   (FW_MAJOR),
      .FW_MINOR   (FW_MINOR)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ctrl_q    (ctrl)
   );

   blink_prescaler #(
      .BLINK_N (BLINK_N)
   ) i_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .fast_ph (fast_ph),
      .slow_ph (slow_ph)
   );

   assign clk_sel      = ctrl.clk_code;
   assign ctl_rst      = ctrl.hold;
   assign chan_mode[0] = ctrl.led0;
   assign chan_mode[1] = ctrl.led1;

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      led_lamp i_lamp (
         .mode    (chan_mode[c]),
         .fast_ph (fast_ph),
         .slow_ph (slow_ph),
         .led_n   (led_n[c])
      );

      AST_LED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
         (chan_mode[c] == LED_DARK) |-> led_n[c]); // R5

      AST_LED_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
         (chan_mode[c] == LED_STEADY) |-> !led_n[c]); // R5

      AST_FAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (chan_mode[c] == LED_FAST) |-> (led_n[c] == !fast_ph)); // R6
   end

endmodule

// File: tb/test_chanctl_led_reg.sv
`timescale 1ns/100ps
module test_chanctl_led_reg;

   localparam int         ADDR_W  = 7;
   localparam int         BLINK_N = 3;
   localparam logic [7:0] FWMAJ   = 8'h02;
   localparam logic [7:0] FWMIN   = 8'h05;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic [1:0]        clk_sel;
   logic [1:0]        ctl_rst;
   logic [1:0]        led_n;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   chanctl_led_reg #(
      .ADDR_W   (ADDR_W),
      .FW_MAJOR (FWMAJ),
      .FW_MINOR (FWMIN),
      .BLINK_N  (BLINK_N)
   ) i_chanctl_led_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .clk_sel   (clk_sel),
      .ctl_rst   (ctl_rst),
      .led_n     (led_n)
   );

   // behavioural reference
   logic [7:0] m_ctrl;
   int         m_cnt;
   bit         m_chg;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl <= 8'hFC;
         m_cnt  <= 0;
         m_chg  <= 1'b0;
      end else begin
         m_cnt <= m_cnt + 1;
         m_chg <= 1'b0;
         if (bus_wr && bus_addr == 7'h40) begin
            m_chg  <= (bus_wdata[7:4] != m_ctrl[7:4]);
            m_ctrl <= bus_wdata;
         end
      end
   end

   function automatic logic exp_led_n(input logic [1:0] mode, input int cnt);
      case (mode)
         2'b00:   return 1'b0;
         2'b01:   return !((cnt >> BLINK_N) & 1);
         2'b10:   return !((cnt >> (BLINK_N + 2)) & 1);
         default: return 1'b1;
      endcase
   endfunction

   function automatic string led_tag(input logic [1:0] mode, input bit chg);
      if (chg) return "R8";
      case (mode)
         2'b01:   return "R6";
         2'b10:   return "R7";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual 0x%02h expected 0x%02h", tag, $time, act, exp);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         logic [7:0] er;
         string      rtag;
         if (!rst_n) begin
            check("R1 ctrl", bus_rdata, (bus_addr == 7'h40) ? 8'hFC : bus_rdata);
            check("R1 clk_sel", {6'd0, clk_sel}, 8'h00);
            check("R1 ctl_rst", {6'd0, ctl_rst}, 8'h03);
            check("R1 led_n", {6'd0, led_n}, 8'h03);
         end else begin
            case (bus_addr)
               7'h40:   begin er = m_ctrl; rtag = "R2"; end
               7'h50:   begin er = FWMAJ;  rtag = "R9"; end
               7'h52:   begin er = FWMIN;  rtag = "R9"; end
               default: begin er = 8'h00;  rtag = "R10"; end
            endcase
            check(rtag, bus_rdata, er);
            check("R3", {6'd0, clk_sel}, {6'd0, m_ctrl[1:0]});
            check("R4", {6'd0, ctl_rst}, {6'd0, m_ctrl[3:2]});
            check(led_tag(m_ctrl[5:4], m_chg), {7'd0, led_n[0]},
                  {7'd0, exp_led_n(m_ctrl[5:4], m_cnt)});
            check(led_tag(m_ctrl[7:6], m_chg), {7'd0, led_n[1]},
                  {7'd0, exp_led_n(m_ctrl[7:6], m_cnt)});
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n, input logic [ADDR_W-1:0] a);
      bus_wr   = 1'b0;
      bus_addr = a;
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      step();
      bus_wr    = 1'b0;
      bus_addr  = 7'h40;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      // R1: reset held for a few cycles, read the control address
      bus_addr = 7'h40;
      repeat (3) step();
      rst_n = 1'b1;
      // reset value held: LEDs dark, counter runs (R5)
      idle(40, 7'h40);
      // release resets, clock code 16 MHz, both LEDs steady (R3 R4 R5)
      wr(7'h40, 8'h00);
      idle(10, 7'h40);
      // ch0 fast, ch1 slow, clock code 01 (R6 R7)
      wr(7'h40, 8'h91);
      idle(100, 7'h40);
      // swap modes mid period, counter not restarted (R8)
      idle(3, 7'h40);
      wr(7'h40, 8'h66);
      idle(90, 7'h40);
      // one steady, one dark, only ch1 held in reset, clock code 11 (R4 R5)
      wr(7'h40, 8'hCB);
      idle(12, 7'h40);
      // firmware bytes, writes there ignored (R9)
      idle(2, 7'h50);
      idle(2, 7'h52);
      wr(7'h50, 8'h11);
      wr(7'h52, 8'h22);
      idle(3, 7'h40);
      // unmapped addresses read zero, writes ignored (R10)
      idle(2, 7'h41);
      wr(7'h41, 8'h00);
      wr(7'h00, 8'h55);
      wr(7'h7F, 8'hAA);
      idle(3, 7'h40);
      // quick mode changes on consecutive cycles (R8)
      wr(7'h40, 8'h50);
      wr(7'h40, 8'hA1);
      wr(7'h40, 8'h16);
      idle(70, 7'h40);
      // reset again mid-run (R1)
      rst_n = 1'b0;
      idle(3, 7'h40);
      rst_n = 1'b1;
      idle(20, 7'h40);
      wr(7'h40, 8'h90);
      idle(300, 7'h40);
      finish_run();
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule